// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the address-sequencing half of a microprogrammed control unit, together with its control store. A 7-bit control address register selects one of 128 micro-instruction words held in a read-only store. The store's contents are computed by a function at elaboration time. The three 3-bit micro-operation fields of the selected word are driven straight out to the datapath within the same cycle. The datapath decodes them; that decoding is outside this block.

Every clock edge the sequencer loads a new control address. The word's branch-type field picks one of four methods for forming it: a conditional jump, a conditional subroutine call, a return, or a mapping from the 4-bit instruction opcode. The jump and call methods fall back to address+1 when their condition is false. The word's condition-select field picks either a constant true or one of three external status inputs. A single return register holds the address saved by the most recent call that was taken.

The store contents are a fixed formula of the word address `a`. The fields are: uop1 = a mod 8, uop2 = (a/8) mod 8, uop3 = (a/16) mod 8, condition select = (a/4) mod 4, branch type = (a mod 4) XOR ((a/32) mod 4), branch target = (37·a + 11) mod 128.

Top module: `ucs_sequencer`

## Requirements
- R1: While `rst_n` is low, the control address is 0. The return register is also cleared to 0, so a return taken before any call goes to address 0.
- R2: The outputs `uop1`, `uop2` and `uop3` equal the fields of the word at the current control address, following the content formula above (uop1 = a mod 8, uop2 = (a/8) mod 8, uop3 = (a/16) mod 8). They follow the address combinationally, in the same cycle.
- R3: The condition comes from the condition-select code. Code 0 is always true, code 1 selects `status[0]`, code 2 selects `status[1]` and code 3 selects `status[2]`.
- R4: Branch type 0 (jump) loads the branch target when the condition is true. Otherwise it loads address+1 modulo 128, so 127 is followed by 0.
- R5: Branch type 1 (call) with a true condition loads the branch target and saves address+1 modulo 128 in the return register. With a false condition it loads address+1 and leaves the return register unchanged.
- R6: Branch type 2 (return) loads the return register whatever the condition, and leaves the return register unchanged. Jump and mapping words also leave the return register unchanged.
- R7: Branch type 3 (map) loads the address formed as 0 in bit 6, `opcode[3:0]` in bits 5..2, and 0 in bits 1..0, that is 4·opcode, whatever the condition.
- R8: `opcode` and `status` act only at the clock edge. Changing them between edges leaves `car_addr` and the `uop` outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| opcode | input | 4 | Instruction opcode used by the map branch |
| status | input | 3 | Status bits selectable as branch conditions |
| car_addr | output | 7 | Current control address |
| uop1 | output | 3 | First micro-operation field of the current word |
| uop2 | output | 3 | Second micro-operation field of the current word |
| uop3 | output | 3 | Third micro-operation field of the current word |

## Verification
The control address is the sequencer's whole visible state, and every word's fields are a known function of it. A wrong next-address choice therefore shows on `car_addr` and on all three `uop` outputs one clock after the faulty edge. A corrupted return register stays hidden until the next return word executes. At that point the address jumps to the wrong place, and from then on the word sequence diverges from the model. The bench drives random opcodes and status bits over several reset episodes, and compares address and fields against a behavioural model every cycle.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

  // Geometry of the control store and its micro-instruction word
  parameter int ADDR_W = 7;
  parameter int UOP_W  = 3;
  parameter int CSEL_W = 2;
  parameter int BT_W   = 2;
  parameter int OPC_W  = 4;
  parameter int STAT_W = 3;

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int MAP_LSB_W = 2;
  localparam int MAP_PAD_W = ADDR_W - OPC_W - MAP_LSB_W;
  localparam int WORD_W    = 3 * UOP_W + CSEL_W + BT_W + ADDR_W;

  // Content formula constants for the target field
  localparam int TGT_MUL = 37;
  localparam int TGT_ADD = 11;

  // Branch-type codes
  localparam logic [BT_W-1:0] BT_JUMP = 2'd0;
  localparam logic [BT_W-1:0] BT_CALL = 2'd1;
  localparam logic [BT_W-1:0] BT_RET  = 2'd2;
  localparam logic [BT_W-1:0] BT_MAP  = 2'd3;

  typedef struct packed {
    logic [UOP_W-1:0]  uop1;
    logic [UOP_W-1:0]  uop2;
    logic [UOP_W-1:0]  uop3;
    logic [CSEL_W-1:0] csel;
    logic [BT_W-1:0]   btype;
    logic [ADDR_W-1:0] target;
  } uword_t;

  // Control-store content as a function of the word address
  function automatic uword_t cs_word(input logic [ADDR_W-1:0] a);
    uword_t w;
    logic [ADDR_W-1:0] mul_k;
    logic [ADDR_W-1:0] add_k;
    mul_k    = ADDR_W'(TGT_MUL);
    add_k    = ADDR_W'(TGT_ADD);
    w.uop1   = a[2:0];
    w.uop2   = a[5:3];
    w.uop3   = a[6:4];
    w.csel   = a[3:2];
    w.btype  = a[1:0] ^ a[6:5];
    w.target = (a * mul_k) + add_k;
    return w;
  endfunction

endpackage

// File: rtl/ucs_rom.sv
module ucs_rom
  import ucs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);

  uword_t table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign table_w[i] = cs_word(ADDR_W'(i));
  end

  // Asynchronous read: the word follows the address in the same cycle
  assign word = table_w[addr];

endmodule

// File: rtl/ucs_cond.sv
module ucs_cond
  import ucs_pkg::*;
(
  input  logic [CSEL_W-1:0] csel,
  input  logic [STAT_W-1:0] status,
  output logic              cond_ok
);

  localparam int NSRC = 1 << CSEL_W;

  logic [NSRC-1:0] src;

  // Source 0 is constant true; sources 1.. map onto the status bits
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (k == 0) begin : g_true
      assign src[k] = 1'b1;
    end else if (k <= STAT_W) begin : g_stat
      assign src[k] = status[k-1];
    end else begin : g_unused
      assign src[k] = 1'b0;
    end
  end

  assign cond_ok = src[csel];

endmodule

// File: rtl/ucs_next.sv
module ucs_next
  import ucs_pkg::*;
(
  input  logic [ADDR_W-1:0] car_q,
  input  logic [ADDR_W-1:0] ret_q,
  input  uword_t            word,
  input  logic              cond_ok,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] car_d,
  output logic [ADDR_W-1:0] ret_d,
  output logic              ret_en
);

  logic [ADDR_W-1:0] incr;
  logic [ADDR_W-1:0] map_addr;

  assign incr     = car_q + ADDR_W'(1);
  assign map_addr = {{MAP_PAD_W{1'b0}}, opcode, {MAP_LSB_W{1'b0}}};
  assign ret_d    = incr;

  always_comb begin
    car_d  = incr;
    ret_en = 1'b0;
    case (word.btype)
      BT_JUMP: begin
        if (cond_ok) car_d = word.target;
      end
      BT_CALL: begin
        if (cond_ok) begin
          car_d  = word.target;
          ret_en = 1'b1;
        end
      end
      BT_RET:  car_d = ret_q;
      BT_MAP:  car_d = map_addr;
      default: car_d = incr;
    endcase
  end

endmodule

// File: rtl/ucs_regs.sv
module ucs_regs
  import ucs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] car_d,
  input  logic [ADDR_W-1:0] ret_d,
  input  logic              ret_en,
  output logic [ADDR_W-1:0] car_q,
  output logic [ADDR_W-1:0] ret_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) car_q <= '0;
    else        car_q <= car_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ret_q <= '0;
    else if (ret_en) ret_q <= ret_d;
  end

endmodule

// File: rtl/ucs_sequencer.sv
module ucs_sequencer
  import ucs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [STAT_W-1:0] status,
  output logic [ADDR_W-1:0] car_addr,
  output logic [UOP_W-1:0]  uop1,
  output logic [UOP_W-1:0]  uop2,
  output logic [UOP_W-1:0]  uop3
);

  logic [ADDR_W-1:0] car_q;
  logic [ADDR_W-1:0] ret_q;
  logic [ADDR_W-1:0] car_d;
  logic [ADDR_W-1:0] ret_d;
  logic              ret_en;
  logic              cond_ok;
  uword_t            cur_word;

  ucs_rom u_rom (
    .addr (car_q),
    .word (cur_word)
  );

  ucs_cond u_cond (
    .csel    (cur_word.csel),
    .status  (status),
    .cond_ok (cond_ok)
  );

  ucs_next u_next (
    .car_q   (car_q),
    .ret_q   (ret_q),
    .word    (cur_word),
    .cond_ok (cond_ok),
    .opcode  (opcode),
    .car_d   (car_d),
    .ret_d   (ret_d),
    .ret_en  (ret_en)
  );

  ucs_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .car_d  (car_d),
    .ret_d  (ret_d),
    .ret_en (ret_en),
    .car_q  (car_q),
    .ret_q  (ret_q)
  );

  assign car_addr = car_q;
  assign uop1     = cur_word.uop1;
  assign uop2     = cur_word.uop2;
  assign uop3     = cur_word.uop3;

endmodule

// File: rtl/ucs_checker.sv
module ucs_checker
  import ucs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [OPC_W-1:0]  opcode,
  input logic [ADDR_W-1:0] car,
  input logic [ADDR_W-1:0] ret,
  input logic              cond_ok,
  input uword_t            cur
);

  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.btype == BT_JUMP && cond_ok) |=> (car == $past(cur.target)))
    else $error("jump target not loaded"); // R4

  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur.btype == BT_JUMP || cur.btype == BT_CALL) && !cond_ok)
      |=> (car == $past(car) + ADDR_W'(1)))
    else $error("fall-through not address+1"); // R4

  AST_CALL_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.btype == BT_CALL && cond_ok)
      |=> (ret == $past(car) + ADDR_W'(1) && car == $past(cur.target)))
    else $error("call did not save return address"); // R5

  AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.btype == BT_RET) |=> (car == $past(ret)))
    else $error("return did not load saved address"); // R6

  AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cur.btype == BT_CALL && cond_ok) |=> $stable(ret))
    else $error("return register changed without call"); // R6

  AST_MAP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.btype == BT_MAP) |=> (car == {1'b0, $past(opcode), 2'b00}))
    else $error("map address wrong"); // R7

  AST_COND_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.csel == '0) |-> cond_ok)
    else $error("select code 0 not true"); // R3

endmodule

bind ucs_sequencer ucs_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .opcode  (opcode),
  .car     (car_q),
  .ret     (ret_q),
  .cond_ok (cond_ok),
  .cur     (cur_word)
);

// File: tb/sim_ucs_sequencer.sv
`timescale 1ns/1ps
module sim_ucs_sequencer;

  logic       clk;
  logic       rst_n;
  logic [3:0] opcode;
  logic [2:0] status;
  logic [6:0] car_addr;
  logic [2:0] uop1, uop2, uop3;

  int tests_run;
  int tests_failed;
  bit finished;

  int ref_car;
  int ref_ret;
  string tag;
  int n_jump, n_inc, n_call, n_ret, n_map;

  ucs_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .status(status),
    .car_addr(car_addr), .uop1(uop1), .uop2(uop2), .uop3(uop3)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare address and all three fields with the model's current address
  task automatic check_outputs(input string req);
    check({req, " car_addr"}, int'(car_addr), ref_car);
    check("R2 uop1", int'(uop1), ref_car % 8);
    check("R2 uop2", int'(uop2), (ref_car / 8) % 8);
    check("R2 uop3", int'(uop3), (ref_car / 16) % 8);
  endtask

  // Behavioural model of one step, using the inputs present at the edge
  task automatic model_step();
    int csel, bt, tgt;
    bit c;
    csel = (ref_car / 4) % 4;
    bt   = (ref_car % 4) ^ ((ref_car / 32) % 4);
    tgt  = (37 * ref_car + 11) % 128;
    c    = (csel == 0) ? 1'b1 : status[csel-1];
    case (bt)
      0: begin
        if (c) begin ref_car = tgt; tag = "R4 jump (cond R3)"; n_jump++; end
        else   begin ref_car = (ref_car + 1) % 128; tag = "R4 increment (cond R3)"; n_inc++; end
      end
      1: begin
        if (c) begin
          ref_ret = (ref_car + 1) % 128;
          ref_car = tgt;
          tag = "R5 call taken (cond R3)"; n_call++;
        end else begin
          ref_car = (ref_car + 1) % 128; tag = "R5 call skipped (cond R3)"; n_inc++;
        end
      end
      2: begin ref_car = ref_ret; tag = "R6 return"; n_ret++; end
      default: begin ref_car = int'(opcode) * 4; tag = "R7 map"; n_map++; end
    endcase
  endtask

  initial begin
    tests_run = 0; tests_failed = 0; finished = 0;
    n_jump = 0; n_inc = 0; n_call = 0; n_ret = 0; n_map = 0;
    rst_n = 1'b0; opcode = '0; status = '0;
    for (int ep = 0; ep < 4; ep++) begin
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      ref_car = 0; ref_ret = 0;
      check_outputs("R1 reset");
      rst_n = 1'b1;
      for (int cyc = 0; cyc < 4000; cyc++) begin
        opcode = 4'($urandom);
        status = 3'($urandom);
        model_step();
        @(negedge clk);
        check_outputs(tag);
        // Inputs move between edges: outputs must hold
        opcode = ~opcode;
        status = ~status;
        #1;
        check_outputs("R8 mid-cycle input change");
      end
    end
    $display("[TB] modes seen: jump=%0d inc=%0d call=%0d ret=%0d map=%0d",
             n_jump, n_inc, n_call, n_ret, n_map);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

endmodule